// File: doc/BRIEF.md
# Path Alarm Consequent-Action Controller

This block turns a set of already-debounced path defect states into the two consequent actions a path terminator has to take. It decides whether the outgoing payload is replaced by an all-ones alarm indication signal (AIS). It also decides whether a remote defect indication (RDI) request goes back toward the far end. Three defects are considered: a signal label mismatch, a trace identifier mismatch and an unequipped condition.

Configuration inputs shape both actions. One bit suppresses defect-driven AIS. A second bit forces AIS whatever the defects are. Two more bits pick which of the label mismatch and the unequipped condition may raise RDI, so the block can match the behaviour of older equipment.

Decisions are sampled only on a frame-start strobe and then held for the whole frame, so a frame is either wholly replaced or wholly passed. The byte stream passes through one register stage, and its valid timing is kept unchanged.

Top module: `path_alarm_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ais_active`, `rdi_request`, `out_valid` and `out_data` are all 0.
- R2: At a frame-start strobe with neither disable nor force set, `ais_active` becomes 1 if any of `dft_label_mm`, `dft_trace_mm` or `dft_unequipped` is 1, and becomes 0 if none is.
- R3: At a frame-start strobe with `cfg_ais_off`=1 and `cfg_ais_force`=0, `ais_active` becomes 0 whatever the defects are.
- R4: At a frame-start strobe with `cfg_ais_force`=1, `ais_active` becomes 1 whatever the defects and `cfg_ais_off` are. Force outranks disable, and disable outranks the defects.
- R5: At a frame-start strobe, `rdi_request` becomes (`dft_label_mm` AND `cfg_rdi_label_en`) OR (`dft_unequipped` AND `cfg_rdi_uneq_en`). The trace mismatch, `cfg_ais_off` and `cfg_ais_force` have no effect on it.
- R6: `ais_active` and `rdi_request` change only in the cycle after a cycle with `frame_start`=1. Defect and configuration changes between strobes have no effect until the next strobe.
- R7: `out_valid` equals `in_valid` delayed by one clock. When `ais_active` is 1, every valid output byte is all ones (8'hFF at the default width). Otherwise `out_data` equals `in_data` delayed by one clock.
- R8: The byte presented together with `frame_start` is already handled by the decision taken at that strobe. Its output appears in the same cycle that `ais_active` and `rdi_request` take their new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | High with the first byte of each frame |
| dft_label_mm | input | 1 | Signal label mismatch defect |
| dft_trace_mm | input | 1 | Trace identifier mismatch defect |
| dft_unequipped | input | 1 | Unequipped defect |
| cfg_ais_off | input | 1 | Suppress defect-driven AIS |
| cfg_ais_force | input | 1 | Force AIS unconditionally |
| cfg_rdi_label_en | input | 1 | Let label mismatch raise RDI |
| cfg_rdi_uneq_en | input | 1 | Let unequipped raise RDI |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DATA_W | Input payload byte |
| out_valid | output | 1 | Output byte valid, one cycle after input |
| out_data | output | DATA_W | Output payload byte, all ones under AIS |
| ais_active | output | 1 | AIS replacement in effect for the current frame |
| rdi_request | output | 1 | Remote defect indication request |

## Verification
Each defect is applied alone at a strobe to show that any single one triggers AIS. An empty defect set follows to show that AIS clears. Disable and force are crossed with and without defects, which separates the two priority orders. The RDI enable bits are swept against label-only, unequipped-only and trace-only defects to show which sources feed RDI and that AIS controls leave it alone. Defects are toggled in the middle of a frame, with idle gaps in the byte stream, to tell strobe-gated updates from immediate ones. Each frame's first byte is checked on its own, which separates the bypassed decision from one applied a byte late.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef struct packed {
        logic label_mm;
        logic trace_mm;
        logic unequipped;
    } defects_t;

    typedef struct packed {
        logic ais_off;
        logic ais_force;
        logic rdi_label_en;
        logic rdi_uneq_en;
    } cfg_t;

    typedef struct packed {
        logic ais;
        logic rdi;
    } action_t;

    localparam action_t ACTION_IDLE = '{ais: 1'b0, rdi: 1'b0};

    // Priority: force, then disable, then any defect.
    function automatic logic ais_rule(input defects_t d, input cfg_t c);
        logic any_defect;
        any_defect = d.label_mm | d.trace_mm | d.unequipped;
        if (c.ais_force)
            return 1'b1;
        else if (c.ais_off)
            return 1'b0;
        else
            return any_defect;
    endfunction

    function automatic logic rdi_rule(input defects_t d, input cfg_t c);
        return (d.label_mm & c.rdi_label_en) | (d.unequipped & c.rdi_uneq_en);
    endfunction

endpackage

// File: rtl/pac_decide.sv
module pac_decide
    import pac_pkg::*;
(
    input  defects_t defects,
    input  cfg_t     cfg,
    output action_t  action
);
    always_comb begin
        action.ais = ais_rule(defects, cfg);
        action.rdi = rdi_rule(defects, cfg);
    end
endmodule

// File: rtl/pac_frame_hold.sv
module pac_frame_hold
    import pac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_start,
    input  action_t next_action,
    output action_t held_action,
    output action_t live_action
);
    action_t state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ACTION_IDLE;
        else if (frame_start)
            state_q <= next_action;
    end

    // The byte that arrives with the strobe already belongs to the new frame.
    always_comb begin
        held_action = state_q;
        live_action = frame_start ? next_action : state_q;
    end
endmodule

// File: rtl/pac_substitute.sv
module pac_substitute #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              replace,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= replace ? ALL_ONES : in_data;
        end
    end
endmodule

// File: rtl/path_alarm_ctrl.sv
module path_alarm_ctrl
    import pac_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              dft_label_mm,
    input  logic              dft_trace_mm,
    input  logic              dft_unequipped,
    input  logic              cfg_ais_off,
    input  logic              cfg_ais_force,
    input  logic              cfg_rdi_label_en,
    input  logic              cfg_rdi_uneq_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              ais_active,
    output logic              rdi_request
);
    defects_t defects;
    cfg_t     cfg;
    action_t  next_action;
    action_t  held_action;
    action_t  live_action;

    always_comb begin
        defects.label_mm     = dft_label_mm;
        defects.trace_mm     = dft_trace_mm;
        defects.unequipped   = dft_unequipped;
        cfg.ais_off          = cfg_ais_off;
        cfg.ais_force        = cfg_ais_force;
        cfg.rdi_label_en     = cfg_rdi_label_en;
        cfg.rdi_uneq_en      = cfg_rdi_uneq_en;
    end

    pac_decide u_decide (
        .defects (defects),
        .cfg     (cfg),
        .action  (next_action)
    );

    pac_frame_hold u_hold (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .next_action (next_action),
        .held_action (held_action),
        .live_action (live_action)
    );

    pac_substitute #(.DATA_W(DATA_W)) u_subst (
        .clk       (clk),
        .rst       (rst),
        .replace   (live_action.ais),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign ais_active  = held_action.ais;
    assign rdi_request = held_action.rdi;
endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              dft_label_mm,
    input logic              dft_trace_mm,
    input logic              dft_unequipped,
    input logic              cfg_ais_off,
    input logic              cfg_ais_force,
    input logic              cfg_rdi_label_en,
    input logic              cfg_rdi_uneq_en,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              ais_active,
    input logic              rdi_request
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!ais_active && !rdi_request && !out_valid));

    p_defect_r2: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !cfg_ais_off && !cfg_ais_force)
        |=> (ais_active == $past(dft_label_mm | dft_trace_mm | dft_unequipped)));

    p_disable_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_start && cfg_ais_off && !cfg_ais_force) |=> !ais_active);

    p_force_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_start && cfg_ais_force) |=> ais_active);

    p_rdi_r5: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (rdi_request ==
            $past((dft_label_mm & cfg_rdi_label_en) | (dft_unequipped & cfg_rdi_uneq_en))));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(ais_active) && $stable(rdi_request)));

    p_valid_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    p_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (ais_active && out_valid) |-> (out_data == {DATA_W{1'b1}}));

    p_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cfg_ais_force && cfg_ais_off)
        |=> (ais_active || (out_data == $past(in_data))));
endmodule

bind path_alarm_ctrl pac_checker #(.DATA_W(DATA_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .frame_start      (frame_start),
    .dft_label_mm     (dft_label_mm),
    .dft_trace_mm     (dft_trace_mm),
    .dft_unequipped   (dft_unequipped),
    .cfg_ais_off      (cfg_ais_off),
    .cfg_ais_force    (cfg_ais_force),
    .cfg_rdi_label_en (cfg_rdi_label_en),
    .cfg_rdi_uneq_en  (cfg_rdi_uneq_en),
    .in_valid         (in_valid),
    .in_data          (in_data),
    .out_valid        (out_valid),
    .out_data         (out_data),
    .ais_active       (ais_active),
    .rdi_request      (rdi_request)
);

// File: tb/path_alarm_ctrl_tb.sv
module path_alarm_ctrl_tb;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic dft_label_mm = 1'b0, dft_trace_mm = 1'b0, dft_unequipped = 1'b0;
    logic cfg_ais_off = 1'b0, cfg_ais_force = 1'b0;
    logic cfg_rdi_label_en = 1'b0, cfg_rdi_uneq_en = 1'b0;
    logic in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic out_valid;
    logic [DATA_W-1:0] out_data;
    logic ais_active, rdi_request;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    path_alarm_ctrl #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start),
        .dft_label_mm(dft_label_mm), .dft_trace_mm(dft_trace_mm),
        .dft_unequipped(dft_unequipped),
        .cfg_ais_off(cfg_ais_off), .cfg_ais_force(cfg_ais_force),
        .cfg_rdi_label_en(cfg_rdi_label_en), .cfg_rdi_uneq_en(cfg_rdi_uneq_en),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .ais_active(ais_active), .rdi_request(rdi_request)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic model_ais();
        if (cfg_ais_force) return 1'b1;
        if (cfg_ais_off) return 1'b0;
        return dft_label_mm | dft_trace_mm | dft_unequipped;
    endfunction

    function automatic logic model_rdi();
        return (dft_label_mm & cfg_rdi_label_en) | (dft_unequipped & cfg_rdi_uneq_en);
    endfunction

    task automatic set_env(input logic l, input logic t, input logic u,
                           input logic off, input logic frc, input logic rl, input logic ru);
        dft_label_mm = l; dft_trace_mm = t; dft_unequipped = u;
        cfg_ais_off = off; cfg_ais_force = frc;
        cfg_rdi_label_en = rl; cfg_rdi_uneq_en = ru;
    endtask

    // Sends one frame; inputs change on falling edges, outputs are read one
    // falling edge later (one register stage). flip_at >= 0 inverts every
    // defect and config bit just before that byte (mid-frame change).
    task automatic run_frame(input string req, input int len, input int flip_at,
                             input int gap_at, input logic [7:0] base);
        logic exp_ais, exp_rdi;
        exp_ais = model_ais();
        exp_rdi = model_rdi();
        for (int i = 0; i < len; i++) begin
            if (i == flip_at) begin
                set_env(~dft_label_mm, ~dft_trace_mm, ~dft_unequipped,
                        ~cfg_ais_off, ~cfg_ais_force, ~cfg_rdi_label_en, ~cfg_rdi_uneq_en);
            end
            if (i == gap_at) begin
                in_valid = 1'b0;
                frame_start = 1'b0;
                @(negedge clk);
                check({req, " R7 gap valid"}, 32'(out_valid), 32'd0);
            end
            frame_start = (i == 0);
            in_valid = 1'b1;
            in_data = base + 8'(i);
            @(negedge clk);
            if (i == 0) begin
                check({req, " R8 first byte data"}, 32'(out_data),
                      exp_ais ? 32'hFF : 32'(base));
            end else begin
                check({req, " R7 byte data"}, 32'(out_data),
                      exp_ais ? 32'hFF : 32'(base + 8'(i)));
            end
            check({req, " R7 valid"}, 32'(out_valid), 32'd1);
            check({req, " R6 ais held"}, 32'(ais_active), 32'(exp_ais));
            check({req, " R6 rdi held"}, 32'(rdi_request), 32'(exp_rdi));
        end
        frame_start = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check({req, " R7 idle valid"}, 32'(out_valid), 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b1;
        frame_start = 1'b1;
        set_env(1, 1, 1, 0, 1, 1, 1);
        repeat (3) @(negedge clk);
        check("R1 ais in reset", 32'(ais_active), 32'd0);
        check("R1 rdi in reset", 32'(rdi_request), 32'd0);
        check("R1 valid in reset", 32'(out_valid), 32'd0);
        check("R1 data in reset", 32'(out_data), 32'd0);
        in_valid = 1'b0;
        frame_start = 1'b0;
        set_env(0, 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ais after reset", 32'(ais_active), 32'd0);
        check("R1 valid after reset", 32'(out_valid), 32'd0);
    endtask

    task automatic t_defects_r2();
        set_env(1, 0, 0, 0, 0, 0, 0); run_frame("R2 label", 3, -1, -1, 8'h10);
        set_env(0, 0, 0, 0, 0, 0, 0); run_frame("R2 clear", 3, -1, -1, 8'h20);
        set_env(0, 1, 0, 0, 0, 0, 0); run_frame("R2 trace", 3, -1, -1, 8'h30);
        set_env(0, 0, 1, 0, 0, 0, 0); run_frame("R2 uneq", 3, -1, -1, 8'h40);
        set_env(0, 0, 0, 0, 0, 0, 0); run_frame("R2 none", 3, -1, -1, 8'h50);
    endtask

    task automatic t_disable_r3();
        set_env(1, 1, 1, 1, 0, 0, 0); run_frame("R3 all defects off", 4, -1, -1, 8'h60);
        set_env(0, 1, 0, 1, 0, 0, 0); run_frame("R3 trace off", 2, -1, -1, 8'h68);
    endtask

    task automatic t_force_r4();
        set_env(0, 0, 0, 0, 1, 0, 0); run_frame("R4 force clean", 3, -1, -1, 8'h70);
        set_env(1, 0, 1, 1, 1, 0, 0); run_frame("R4 force over off", 3, -1, -1, 8'h78);
        set_env(0, 0, 0, 1, 0, 0, 0); run_frame("R4 release", 2, -1, -1, 8'h7C);
    endtask

    task automatic t_rdi_r5();
        set_env(1, 0, 0, 0, 0, 1, 0); run_frame("R5 label en", 2, -1, -1, 8'h80);
        set_env(1, 0, 0, 0, 0, 0, 1); run_frame("R5 label masked", 2, -1, -1, 8'h84);
        set_env(0, 0, 1, 0, 0, 0, 1); run_frame("R5 uneq en", 2, -1, -1, 8'h88);
        set_env(0, 0, 1, 0, 0, 1, 0); run_frame("R5 uneq masked", 2, -1, -1, 8'h8C);
        set_env(0, 1, 0, 0, 0, 1, 1); run_frame("R5 trace no rdi", 2, -1, -1, 8'h90);
        set_env(1, 0, 1, 1, 0, 1, 1); run_frame("R5 rdi under off", 2, -1, -1, 8'h94);
        set_env(0, 0, 0, 0, 1, 1, 1); run_frame("R5 force no rdi", 2, -1, -1, 8'h98);
    endtask

    task automatic t_hold_r6();
        set_env(0, 0, 0, 0, 0, 1, 1); run_frame("R6 clean then flip", 5, 2, -1, 8'hA0);
        run_frame("R6 flipped frame", 3, -1, -1, 8'hB0);
        set_env(1, 1, 1, 0, 0, 1, 1); run_frame("R6 alarm then flip", 5, 1, -1, 8'hC0);
    endtask

    task automatic t_stream_r7();
        set_env(0, 0, 0, 0, 0, 0, 0); run_frame("R7 pass gaps", 6, -1, 3, 8'hD0);
        set_env(0, 1, 0, 0, 0, 0, 0); run_frame("R7 fill gaps", 6, -1, 2, 8'hE0);
        set_env(0, 0, 0, 0, 0, 0, 0); run_frame("R7 pass again", 3, -1, -1, 8'h05);
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_defects_r2();
        t_disable_r3();
        t_force_r4();
        t_rdi_r5();
        t_hold_r6();
        t_stream_r7();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule